// File: doc/BRIEF.md
# Line uniformity statistics engine

This block watches a stream of digitized pixel amplitudes that make up one scan line of a contact image sensor. Each sample arrives with a valid strobe and with markers for the first and the last pixel of the line. While the line streams in, the block keeps a running sum, the extremes, a pixel count and the strongest adjacent-pixel step. The previous sample is held in a register, so each adjacent step is judged as soon as its second pixel arrives.

After the last-pixel marker, one shared restoring divider works out the line average. It then works out the peak deviation from that average as a percentage, and the worst adjacent step as a percentage of the earlier pixel. A mode input, sampled with the last pixel, marks the capture as dark (light off) or illuminated. For a dark capture the block reports the spread between the brightest and dimmest pixel instead of the percentages. All figures are published together in output registers with a one-cycle done pulse. Percentages are unsigned fixed point with 8 fractional bits, so 100 % reads as 25600.

Top module: `lsu_top`

## Requirements
- R1: The reported average is floor(sum of the line's pixels / number of pixels actually received in that line).
- R2: The reported maximum and minimum are the largest and smallest pixel of the line.
- R3: For an illuminated line (dark_mode = 0), dev_pct_o = floor(max(max − avg, avg − min) × 25600 / avg), where avg is the R1 value.
- R4: For an illuminated line, adj_pct_o = max over consecutive pixels n, n+1 of floor(|V(n) − V(n+1)| × 25600 / V(n)). The first pixel starts no comparison, and a one-pixel line reports 0.
- R5: For a dark line (dark_mode = 1 on the last pixel), spread_o = max − min and both percentages are 0. For an illuminated line spread_o is 0.
- R6: On an illuminated line, avg = 0 forces dev_pct_o to all ones (2^(PIX_W+15) − 1). Any zero earlier pixel V(n) forces adj_pct_o to all ones. Either case sets zdiv_o, which stays 1 until reset.
- R7: len_err_o is 1 when the received pixel count differs from cfg_len and 0 otherwise, and the figures are still reported. It is re-evaluated on each line.
- R8: res_valid is a single-cycle pulse. All result outputs change only in the cycle it is high and hold their values until the next pulse.
- R9: After reset every result output, res_valid, len_err_o and zdiv_o are 0.
- R10: A sample with pix_first = 1 restarts the accumulation, so any earlier line that never received a last marker has no effect on the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Sample strobe |
| pix_data | input | PIX_W | Pixel amplitude |
| pix_first | input | 1 | Sample is the first of a line |
| pix_last | input | 1 | Sample is the last of a line |
| dark_mode | input | 1 | 1 = dark capture, sampled with the last pixel |
| cfg_len | input | CNT_W | Expected pixel count per line |
| res_valid | output | 1 | One-cycle pulse when results are published |
| avg_o | output | PIX_W | Line average |
| max_o | output | PIX_W | Line maximum |
| min_o | output | PIX_W | Line minimum |
| dev_pct_o | output | PIX_W+15 | Peak deviation percentage, 8 fractional bits |
| spread_o | output | PIX_W | Dark spread (max − min) |
| adj_pct_o | output | PIX_W+15 | Worst adjacent step percentage, 8 fractional bits |
| len_err_o | output | 1 | Pixel count differed from cfg_len |
| zdiv_o | output | 1 | Sticky zero-denominator flag |

## Verification
The last pixel of a line both closes the stream and completes the final adjacent comparison in the same clock edge. The bench therefore feeds lines whose steepest step lies on the final pair, and the random sweep often lands the worst ratio there too. The result must then include that pair's ratio. Likewise, an all-zero illuminated line makes both divisions hit a zero denominator within one result. The bench checks that both percentages saturate and that the flag is set exactly once and then stays set.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  // 100 percent in 8-bit fractional fixed point
  localparam int PCT_SCALE = 25600;

  typedef enum logic [2:0] {
    S_IDLE, S_AVG, S_LDEV, S_DEV, S_LADJ, S_ADJ, S_FIN
  } seq_t;
endpackage

// File: rtl/lsu_accum.sv
module lsu_accum #(
  parameter int PIX_W = 8,
  parameter int CNT_W = 8,
  localparam int SUM_W = PIX_W + CNT_W,
  localparam int PW2   = 2 * PIX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic [PIX_W-1:0] data,
  input  logic             first,
  input  logic             last,
  output logic [SUM_W-1:0] sum_q,
  output logic [PIX_W-1:0] max_q,
  output logic [PIX_W-1:0] min_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [PIX_W-1:0] adj_d_q,
  output logic [PIX_W-1:0] adj_v_q,
  output logic             adj_inf_q,
  output logic             line_end
);
  logic [PIX_W-1:0] prev_q;
  logic [PIX_W-1:0] step;
  logic [PW2-1:0]   cand_x, best_x;

  always_comb begin
    step   = (prev_q > data) ? (prev_q - data) : (data - prev_q);
    // ratio step/prev beats adj_d/adj_v when step*adj_v > adj_d*prev
    cand_x = PW2'(step) * PW2'(adj_v_q);
    best_x = PW2'(adj_d_q) * PW2'(prev_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0; max_q <= '0; min_q <= '0; cnt_q <= '0;
      adj_d_q <= '0; adj_v_q <= PIX_W'(1); adj_inf_q <= 1'b0;
      prev_q <= '0; line_end <= 1'b0;
    end else begin
      line_end <= valid & last;
      if (valid) begin
        prev_q <= data;
        if (first) begin
          sum_q <= SUM_W'(data); max_q <= data; min_q <= data;
          cnt_q <= CNT_W'(1);
          adj_d_q <= '0; adj_v_q <= PIX_W'(1); adj_inf_q <= 1'b0;
        end else begin
          sum_q <= sum_q + SUM_W'(data);
          cnt_q <= cnt_q + CNT_W'(1);
          if (data > max_q) max_q <= data;
          if (data < min_q) min_q <= data;
          if (prev_q == '0) adj_inf_q <= 1'b1;
          else if (cand_x > best_x) begin
            adj_d_q <= step;
            adj_v_q <= prev_q;
          end
        end
      end
    end
  end
endmodule

// File: rtl/lsu_div.sv
module lsu_div #(
  parameter int DW = 23,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          done,
  output logic [DW-1:0] quot
);
  logic [DW-1:0] rem_q, quo_q, dsr_q;
  logic [CW-1:0] cnt_q;
  logic [DW:0]   sh;

  assign sh   = {rem_q, quo_q[DW-1]};
  assign quot = quo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0; quo_q <= '0; dsr_q <= '0; cnt_q <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q <= '0; quo_q <= dividend; dsr_q <= divisor; cnt_q <= CW'(DW);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) done <= 1'b1;
        if (sh >= {1'b0, dsr_q}) begin
          rem_q <= sh[DW-1:0] - dsr_q;
          quo_q <= {quo_q[DW-2:0], 1'b1};
        end else begin
          rem_q <= sh[DW-1:0];
          quo_q <= {quo_q[DW-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/lsu_top.sv
module lsu_top #(
  parameter int PIX_W = 8,
  parameter int CNT_W = 8,
  localparam int PCT_W = PIX_W + 15,
  localparam int SUM_W = PIX_W + CNT_W,
  localparam int DIV_W = (SUM_W > PCT_W) ? SUM_W : PCT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             pix_first,
  input  logic             pix_last,
  input  logic             dark_mode,
  input  logic [CNT_W-1:0] cfg_len,
  output logic             res_valid,
  output logic [PIX_W-1:0] avg_o,
  output logic [PIX_W-1:0] max_o,
  output logic [PIX_W-1:0] min_o,
  output logic [PCT_W-1:0] dev_pct_o,
  output logic [PIX_W-1:0] spread_o,
  output logic [PCT_W-1:0] adj_pct_o,
  output logic             len_err_o,
  output logic             zdiv_o
);
  import lsu_pkg::*;

  logic [SUM_W-1:0] sum_q;
  logic [PIX_W-1:0] mx_q, mn_q, adj_d_q, adj_v_q, avg_r, devv;
  logic [CNT_W-1:0] cnt_q;
  logic             adj_inf_q, line_end, dark_q;
  logic             d_start, d_done;
  logic [DIV_W-1:0] d_num, d_den, d_quot;
  logic [PCT_W-1:0] dev_r, adj_r;
  seq_t             st;

  lsu_accum #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst(rst), .valid(pix_valid), .data(pix_data),
    .first(pix_first), .last(pix_last), .sum_q(sum_q), .max_q(mx_q),
    .min_q(mn_q), .cnt_q(cnt_q), .adj_d_q(adj_d_q), .adj_v_q(adj_v_q),
    .adj_inf_q(adj_inf_q), .line_end(line_end)
  );

  lsu_div #(.DW(DIV_W)) u_div (
    .clk(clk), .rst(rst), .start(d_start), .dividend(d_num),
    .divisor(d_den), .done(d_done), .quot(d_quot)
  );

  always_comb begin
    devv    = ((mx_q - avg_r) > (avg_r - mn_q)) ? (mx_q - avg_r) : (avg_r - mn_q);
    d_start = 1'b0;
    d_num   = '0;
    d_den   = '0;
    case (st)
      S_IDLE: if (line_end) begin
        d_start = 1'b1; d_num = DIV_W'(sum_q); d_den = DIV_W'(cnt_q);
      end
      S_LDEV: if (!dark_q && avg_r != '0) begin
        d_start = 1'b1;
        d_num = DIV_W'(devv) * DIV_W'(PCT_SCALE); d_den = DIV_W'(avg_r);
      end
      S_LADJ: if (!adj_inf_q) begin
        d_start = 1'b1;
        d_num = DIV_W'(adj_d_q) * DIV_W'(PCT_SCALE); d_den = DIV_W'(adj_v_q);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; dark_q <= 1'b0; avg_r <= '0; dev_r <= '0; adj_r <= '0;
      res_valid <= 1'b0; avg_o <= '0; max_o <= '0; min_o <= '0;
      dev_pct_o <= '0; spread_o <= '0; adj_pct_o <= '0;
      len_err_o <= 1'b0; zdiv_o <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (pix_valid && pix_last) dark_q <= dark_mode;
      case (st)
        S_IDLE: if (line_end) st <= S_AVG;
        S_AVG: if (d_done) begin
          avg_r <= d_quot[PIX_W-1:0];
          st    <= S_LDEV;
        end
        S_LDEV: begin
          dev_r <= '0; adj_r <= '0;
          if (dark_q) st <= S_FIN;
          else if (avg_r == '0) begin
            dev_r <= '1; zdiv_o <= 1'b1; st <= S_LADJ;
          end else st <= S_DEV;
        end
        S_DEV: if (d_done) begin
          dev_r <= d_quot[PCT_W-1:0]; st <= S_LADJ;
        end
        S_LADJ: begin
          if (adj_inf_q) begin
            adj_r <= '1; zdiv_o <= 1'b1; st <= S_FIN;
          end else st <= S_ADJ;
        end
        S_ADJ: if (d_done) begin
          adj_r <= d_quot[PCT_W-1:0]; st <= S_FIN;
        end
        default: begin
          res_valid <= 1'b1;
          avg_o     <= avg_r;
          max_o     <= mx_q;
          min_o     <= mn_q;
          dev_pct_o <= dev_r;
          adj_pct_o <= adj_r;
          spread_o  <= dark_q ? (mx_q - mn_q) : '0;
          len_err_o <= (cnt_q != cfg_len);
          st        <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/lsu_chk.sv
module lsu_chk #(
  parameter int PIX_W = 8,
  parameter int PCT_W = PIX_W + 15
) (
  input logic             clk,
  input logic             rst,
  input logic             res_valid,
  input logic [PIX_W-1:0] avg_o,
  input logic [PIX_W-1:0] max_o,
  input logic [PIX_W-1:0] min_o,
  input logic [PCT_W-1:0] dev_pct_o,
  input logic [PIX_W-1:0] spread_o,
  input logic [PCT_W-1:0] adj_pct_o,
  input logic             zdiv_o
);
  p_order_r2: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> max_o >= min_o);

  p_avg_range_r1: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (avg_o >= min_o && avg_o <= max_o));

  p_dark_excl_r5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && spread_o != '0) |-> (dev_pct_o == '0 && adj_pct_o == '0));

  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    zdiv_o |=> zdiv_o);

  p_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> ($stable(avg_o) && $stable(dev_pct_o) && $stable(adj_pct_o)));
endmodule

bind lsu_top lsu_chk #(.PIX_W(PIX_W), .PCT_W(PCT_W)) u_chk (
  .clk(clk), .rst(rst), .res_valid(res_valid), .avg_o(avg_o),
  .max_o(max_o), .min_o(min_o), .dev_pct_o(dev_pct_o),
  .spread_o(spread_o), .adj_pct_o(adj_pct_o), .zdiv_o(zdiv_o)
);

// File: tb/tb_lsu_top.sv
module tb_lsu_top;
  localparam int PW = 8;
  localparam int CW = 8;
  localparam longint ONES = (64'd1 << (PW + 15)) - 1;

  logic clk = 0, rst = 1;
  logic pix_valid = 0, pix_first = 0, pix_last = 0, dark_mode = 0;
  logic [PW-1:0] pix_data = '0;
  logic [CW-1:0] cfg_len = '0;
  logic res_valid, len_err_o, zdiv_o;
  logic [PW-1:0] avg_o, max_o, min_o, spread_o;
  logic [PW+14:0] dev_pct_o, adj_pct_o;

  int errors = 0, checks = 0, cyc = 0;
  bit zexp = 0;
  int px [0:15];

  always #10 clk = ~clk;

  lsu_top #(.PIX_W(PW), .CNT_W(CW)) dut (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input int n, input bit dark, input bit with_last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_valid = 1; pix_data = PW'(px[i]); pix_first = (i == 0);
      pix_last = with_last && (i == n - 1); dark_mode = dark;
    end
    @(negedge clk);
    pix_valid = 0; pix_first = 0; pix_last = 0;
  endtask

  task automatic run_line(input int n, input bit dark, input int cfg, input string tag);
    longint sum = 0, mx = 0, mn = 1 << PW, avg, dv, dev, adj = 0, r;
    bit adjz = 0;
    cfg_len = CW'(cfg);
    for (int i = 0; i < n; i++) begin
      sum += px[i];
      if (px[i] > mx) mx = px[i];
      if (px[i] < mn) mn = px[i];
      if (i > 0) begin
        if (px[i-1] == 0) adjz = 1;
        else begin
          r = ((px[i-1] > px[i]) ? px[i-1] - px[i] : px[i] - px[i-1]) * 25600 / px[i-1];
          if (r > adj) adj = r;
        end
      end
    end
    avg = sum / n;
    dv  = (mx - avg > avg - mn) ? mx - avg : avg - mn;
    if (dark) begin dev = 0; adj = 0; end
    else begin
      dev = (avg == 0) ? ONES : dv * 25600 / avg;
      if (adjz) adj = ONES;
      if (avg == 0 || adjz) zexp = 1;
    end
    drive(n, dark, 1);
    while (!res_valid) @(negedge clk);
    check({tag, " R1 avg"}, avg_o, avg);
    check({tag, " R2 max"}, max_o, mx);
    check({tag, " R2 min"}, min_o, mn);
    check({tag, " R3/R6 dev"}, dev_pct_o, dev);
    check({tag, " R4/R6 adj"}, adj_pct_o, adj);
    check({tag, " R5 spread"}, spread_o, dark ? mx - mn : 0);
    check({tag, " R7 len_err"}, len_err_o, n != cfg);
    check({tag, " R6 zdiv"}, zdiv_o, zexp);
    @(negedge clk);
    check({tag, " R8 pulse"}, res_valid, 0);
    check({tag, " R8 hold"}, avg_o, avg);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R9 reset valid", res_valid, 0);
    check("R9 reset avg", avg_o, 0);
    check("R9 reset dev", dev_pct_o, 0);
    check("R9 reset zdiv", zdiv_o, 0);
    check("R9 reset len_err", len_err_o, 0);

    // R3 R4: flat line
    for (int i = 0; i < 8; i++) px[i] = 100;
    run_line(8, 0, 8, "flat");
    // R4: steepest step on the final pair, closing in the line-end cycle
    for (int i = 0; i < 7; i++) px[i] = 200 - 10 * i;
    px[7] = 20;
    run_line(8, 0, 8, "lastpair");
    // R4: last pixel zero is not an earlier pixel
    for (int i = 0; i < 7; i++) px[i] = 10;
    px[7] = 0;
    run_line(8, 0, 8, "lastzero");
    // R4: single pixel
    px[0] = 77;
    run_line(1, 0, 1, "single");
    // R5: dark capture
    for (int i = 0; i < 6; i++) px[i] = 5 + 3 * i;
    run_line(6, 1, 6, "dark");
    // R7: short line then matched line
    for (int i = 0; i < 5; i++) px[i] = 40 + i;
    run_line(5, 0, 8, "short");
    run_line(5, 0, 5, "matched");
    // R10: aborted line then a fresh line
    for (int i = 0; i < 4; i++) px[i] = 250;
    drive(4, 0, 0);
    for (int i = 0; i < 6; i++) px[i] = 30 + 2 * i;
    run_line(6, 0, 6, "R10 restart");

    // sweep of random lines, nonzero pixels
    for (int t = 0; t < 300; t++) begin
      int n = $urandom_range(1, 16);
      for (int i = 0; i < n; i++) px[i] = $urandom_range(1, 255);
      run_line(n, bit'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0) ? n + 1 : n, "sweep");
    end

    // R6: zero earlier pixel in the middle
    for (int i = 0; i < 8; i++) px[i] = 60;
    px[3] = 0;
    run_line(8, 0, 8, "R6 midzero");
    // R6: all-zero line saturates both in the same result
    for (int i = 0; i < 8; i++) px[i] = 0;
    run_line(8, 0, 8, "R6 allzero");
    // R6: sticky across a clean line
    for (int i = 0; i < 8; i++) px[i] = 90 + i;
    run_line(8, 0, 8, "R6 sticky");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule